// File: doc/BRIEF.md
# Event Memory Writer with Serial Dump

This block captures one event per clock cycle into a 96-entry, 72-bit buffer while an acquisition window (the shutter) is open. A per-cycle operation-mode input chooses the word layout: raw hit bitmaps, up to four stubs, or up to eight centroids. Each layout carries a 16-bit timestamp and, where room is left, a header of ones. Only cycles that carry data are stored. When the buffer is full, later events are dropped and the stored words are kept. An empty flag shows whether anything has been stored since the window opened.

When the shutter falls, the block moves to readout. A slow readout clock, sampled in the system clock domain, shifts the stored words out on one serial pin. The first stored word goes first, and each word goes from its top bit down. Readout is destructive. Opening the shutter again clears the buffer and starts a new acquisition.

The controller is a four-state machine:
- S_IDLE: after reset, nothing to send.
- S_ACQ: the window is open and events are written.
- S_DUMP: the window is closed and words are shifted out.
- S_DRAINED: every stored word has been sent.

Its transitions are:
- S_IDLE, S_DRAINED or S_DUMP go to S_ACQ when the shutter is high.
- S_ACQ goes to S_DUMP when the shutter falls with words stored.
- S_ACQ goes to S_DRAINED when the shutter falls with no word stored.
- S_DUMP goes to S_DRAINED after the last bit of the last word.

Top module: `evt_mem_dump`

## Requirements
- R1: A clock edge that sees the shutter high while the state is not S_ACQ starts an acquisition. It discards all stored words, so none from an earlier window can be read, and it sets empty to 1.
- R2: Mode 2'b11 (raw) forms the word {8'hFF, timestamp[15:0], hits[47:0]}. The word is stored only when hits is nonzero.
- R3: Mode 2'b00 (stub) forms the word {4'hF, timestamp, slot3..slot0}. Slot k is 13 bits at bit 13k and equals stub k when stub_vld[k] is set, otherwise zero. The word is stored only when stub_vld is nonzero.
- R4: Mode 2'b10 (centroid) forms the word {timestamp, slot7..slot0}. Slot k is 7 bits at bit 7k and equals centroid k when cent_vld[k] is set, otherwise zero. There is no header, and the word is stored only when cent_vld is nonzero.
- R5: Mode 2'b01 stores nothing, whatever the payload inputs carry.
- R6: At most 96 words are stored per acquisition. Events after the 96th are dropped, and the first 96 read out unchanged.
- R7: empty is 1 after reset and after an acquisition start. It drops to 0 at the clock edge that stores the first word.
- R8: After the shutter falls, ser_out presents bit 71 of the first stored word. Each falling edge of rd_clk advances one bit, words leave in store order, and rising edges of rd_clk have no effect.
- R9: Once every stored bit has been shifted out, ser_out stays 0 on further rd_clk falling edges.
- R10: While the shutter is high, rd_clk edges are ignored and ser_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one event per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutter | input | 1 | High opens the acquisition window, low enables readout |
| mode | input | 2 | Word layout select: 00 stub, 01 none, 10 centroid, 11 raw |
| hits | input | 48 | Raw hit bitmap for this cycle |
| stubs | input | 52 | Four 13-bit stub slots |
| stub_vld | input | 4 | Per-slot stub valid |
| cents | input | 56 | Eight 7-bit centroid slots |
| cent_vld | input | 8 | Per-slot centroid valid |
| timestamp | input | 16 | Event timestamp |
| rd_clk | input | 1 | Slow readout clock; its falling edges shift data |
| empty | output | 1 | 1 while no word is stored in the current acquisition |
| ser_out | output | 1 | Serial readout data |

## Verification
The hardest situation to reach from the ports is a full buffer that still receives events. It takes 100 consecutive raw events, each with a distinct timestamp, in one shutter window. A complete 96-word dump then follows, and it must show every early timestamp in order and none of the late ones. A second hard case is a shutter reopened over data that was never read: the test stores words, skips readout, stores a single new word, and checks that only that word emerges. rd_clk is also toggled during acquisition, to show that edges seen while the shutter is high leave the later dump untouched.

// File: rtl/evt_mem_pkg.sv
package evt_mem_pkg;
    localparam int WORD_W   = 72;
    localparam int TS_W     = 16;
    localparam int HIT_N    = 48;
    localparam int STUB_N   = 4;
    localparam int STUB_W   = 13;
    localparam int CENT_N   = 8;
    localparam int CENT_W   = 7;
    localparam int DEPTH    = 96;
    localparam int STUB_FLD = STUB_N * STUB_W;
    localparam int CENT_FLD = CENT_N * CENT_W;

    typedef enum logic [1:0] {
        MODE_STUB = 2'b00,
        MODE_EMU  = 2'b01,
        MODE_CENT = 2'b10,
        MODE_RAW  = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ACQ,
        S_DUMP,
        S_DRAINED
    } rd_state_e;
endpackage

// File: rtl/evt_formatter.sv
module evt_formatter
    import evt_mem_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_TS_W   = TS_W,
    parameter int P_HIT_N  = HIT_N,
    parameter int P_STUB_N = STUB_N,
    parameter int P_STUB_W = STUB_W,
    parameter int P_CENT_N = CENT_N,
    parameter int P_CENT_W = CENT_W
) (
    input  logic [1:0]                   mode,
    input  logic [P_HIT_N-1:0]           hits,
    input  logic [P_STUB_N*P_STUB_W-1:0] stubs,
    input  logic [P_STUB_N-1:0]          stub_vld,
    input  logic [P_CENT_N*P_CENT_W-1:0] cents,
    input  logic [P_CENT_N-1:0]          cent_vld,
    input  logic [P_TS_W-1:0]            ts,
    output logic [P_WORD_W-1:0]          word,
    output logic                         has_data
);
    localparam int SFLD = P_STUB_N * P_STUB_W;
    localparam int CFLD = P_CENT_N * P_CENT_W;

    logic [SFLD-1:0] stub_m;
    logic [CFLD-1:0] cent_m;
    op_mode_e        m;

    assign m = op_mode_e'(mode);

    // invalid slots are forced to zero
    for (genvar g = 0; g < P_STUB_N; g++) begin : g_stub
        assign stub_m[g*P_STUB_W +: P_STUB_W] =
            stub_vld[g] ? stubs[g*P_STUB_W +: P_STUB_W] : '0;
    end
    for (genvar g = 0; g < P_CENT_N; g++) begin : g_cent
        assign cent_m[g*P_CENT_W +: P_CENT_W] =
            cent_vld[g] ? cents[g*P_CENT_W +: P_CENT_W] : '0;
    end

    always_comb begin
        word     = '1;
        has_data = 1'b0;
        unique case (m)
            MODE_RAW: begin
                word[P_HIT_N-1:0]       = hits;
                word[P_HIT_N +: P_TS_W] = ts;
                has_data                = |hits;
            end
            MODE_STUB: begin
                word[SFLD-1:0]       = stub_m;
                word[SFLD +: P_TS_W] = ts;
                has_data             = |stub_vld;
            end
            MODE_CENT: begin
                word[CFLD-1:0]       = cent_m;
                word[CFLD +: P_TS_W] = ts;
                has_data             = |cent_vld;
            end
            MODE_EMU: begin
                word     = '0;
                has_data = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/evt_store.sv
module evt_store #(
    parameter int P_DEPTH  = 96,
    parameter int P_WORD_W = 72,
    localparam int ADDR_W  = $clog2(P_DEPTH),
    localparam int CNT_W   = $clog2(P_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [P_WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [P_WORD_W-1:0] rd_word,
    output logic [CNT_W-1:0]    count,
    output logic                empty
);
    logic [P_WORD_W-1:0] mem [P_DEPTH];
    logic                full;
    logic                do_wr;

    assign full    = (count == CNT_W'(P_DEPTH));
    assign do_wr   = wr_en && !full && !clr;
    assign rd_word = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[count[ADDR_W-1:0]] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            empty <= 1'b1;
        end else if (clr) begin
            count <= '0;
            empty <= 1'b1;
        end else if (do_wr) begin
            count <= count + 1'b1;
            empty <= 1'b0;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !clr) |=> $stable(count));
    assert_empty_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty) |-> (count == CNT_W'(1)));
    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && count == '0));
endmodule

// File: rtl/rd_edge.sv
module rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_clk,
    output logic rd_fall
);
    logic [1:0] sync;
    logic       prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync <= '0;
            prev <= 1'b0;
        end else begin
            sync <= {sync[0], rd_clk};
            prev <= sync[1];
        end
    end

    assign rd_fall = prev && !sync[1];
endmodule

// File: rtl/evt_mem_dump.sv
module evt_mem_dump
    import evt_mem_pkg::*;
#(
    parameter int P_DEPTH  = DEPTH,
    parameter int P_WORD_W = WORD_W,
    localparam int ADDR_W  = $clog2(P_DEPTH),
    localparam int CNT_W   = $clog2(P_DEPTH + 1),
    localparam int BIT_W   = $clog2(P_WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shutter,
    input  logic [1:0]           mode,
    input  logic [HIT_N-1:0]     hits,
    input  logic [STUB_FLD-1:0]  stubs,
    input  logic [STUB_N-1:0]    stub_vld,
    input  logic [CENT_FLD-1:0]  cents,
    input  logic [CENT_N-1:0]    cent_vld,
    input  logic [TS_W-1:0]      timestamp,
    input  logic                 rd_clk,
    output logic                 empty,
    output logic                 ser_out
);
    rd_state_e           state, state_nxt;
    logic [P_WORD_W-1:0] fmt_word, rd_word, shreg;
    logic                has_data, rd_fall, clr, wr_en, last_bit;
    logic [CNT_W-1:0]    count, rd_ptr;
    logic [BIT_W-1:0]    bit_cnt;

    evt_formatter #(.P_WORD_W(P_WORD_W)) u_fmt (
        .mode(mode), .hits(hits), .stubs(stubs), .stub_vld(stub_vld),
        .cents(cents), .cent_vld(cent_vld), .ts(timestamp),
        .word(fmt_word), .has_data(has_data)
    );

    evt_store #(.P_DEPTH(P_DEPTH), .P_WORD_W(P_WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
        .wr_word(fmt_word), .rd_addr(rd_ptr[ADDR_W-1:0]),
        .rd_word(rd_word), .count(count), .empty(empty)
    );

    rd_edge u_edge (.clk(clk), .rst_n(rst_n), .rd_clk(rd_clk), .rd_fall(rd_fall));

    assign clr      = shutter && (state != S_ACQ);
    assign wr_en    = (state == S_ACQ) && shutter && has_data;
    assign last_bit = (bit_cnt == BIT_W'(P_WORD_W - 1));
    assign ser_out  = shreg[P_WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE, S_DRAINED: if (shutter) state_nxt = S_ACQ;
            S_ACQ: if (!shutter) state_nxt = (count == '0) ? S_DRAINED : S_DUMP;
            S_DUMP: begin
                if (shutter)                                  state_nxt = S_ACQ;
                else if (rd_fall && last_bit && rd_ptr == count) state_nxt = S_DRAINED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            rd_ptr  <= '0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_DRAINED: begin
                    if (shutter) begin
                        shreg   <= '0;
                        rd_ptr  <= '0;
                        bit_cnt <= '0;
                    end
                end
                S_ACQ: begin
                    if (!shutter && count != '0) begin
                        shreg   <= rd_word;
                        rd_ptr  <= CNT_W'(1);
                        bit_cnt <= '0;
                    end
                end
                S_DUMP: begin
                    if (shutter) begin
                        shreg   <= '0;
                        rd_ptr  <= '0;
                        bit_cnt <= '0;
                    end else if (rd_fall) begin
                        if (last_bit) begin
                            bit_cnt <= '0;
                            if (rd_ptr == count) begin
                                shreg <= '0;
                            end else begin
                                shreg  <= rd_word;
                                rd_ptr <= rd_ptr + 1'b1;
                            end
                        end else begin
                            shreg   <= {shreg[P_WORD_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assert_quiet_acq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACQ) |-> !ser_out);
    assert_drained_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAINED) |-> !ser_out);
    assert_emu_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACQ && shutter && mode == MODE_EMU) |=> $stable(count));
    assert_hold_no_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DUMP && !shutter && !rd_fall) |=> $stable(shreg));
endmodule

// File: tb/evt_mem_dump_bench.sv
module evt_mem_dump_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  mode;
        logic [47:0] hits;
        logic [51:0] stubs;
        logic [3:0]  svld;
        logic [55:0] cents;
        logic [7:0]  cvld;
        logic [15:0] ts;
        logic        wr;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{2'b11, 48'h0000_0000_0001, 52'h0, 4'h0, 56'h0, 8'h00, 16'h0011, 1'b1},
        '{2'b11, 48'h0, 52'hF_FFFF_FFFF_FFFF, 4'hF, 56'h0, 8'h00, 16'h0022, 1'b0},
        '{2'b00, 48'h0, 52'hA_BCDE_F012_3456, 4'b0101, 56'h0, 8'h00, 16'h0033, 1'b1},
        '{2'b00, 48'hFFFF, 52'h1_2345_6789_ABCD, 4'h0, 56'h0, 8'hFF, 16'h0044, 1'b0},
        '{2'b01, 48'h1234_5678, 52'h5_5555_5555_5555, 4'hF, 56'hFF, 8'hFF, 16'h0055, 1'b0},
        '{2'b10, 48'h0, 52'h0, 4'h0, 56'h12_3456_789A_BCDE, 8'b1000_0001, 16'h0066, 1'b1},
        '{2'b11, 48'h8000_0000_0000, 52'h0, 4'h0, 56'h0, 8'h00, 16'hFFFF, 1'b1},
        '{2'b10, 48'h1, 52'h0, 4'h0, 56'hFF_FFFF_FFFF_FFFF, 8'h00, 16'h0077, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shutter = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic [47:0] hits = '0;
    logic [51:0] stubs = '0;
    logic [3:0]  stub_vld = '0;
    logic [55:0] cents = '0;
    logic [7:0]  cent_vld = '0;
    logic [15:0] timestamp = '0;
    logic        rd_clk = 1'b1;
    logic        empty, ser_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    evt_mem_dump u_evt_mem_dump (
        .clk(clk), .rst_n(rst_n), .shutter(shutter), .mode(mode), .hits(hits),
        .stubs(stubs), .stub_vld(stub_vld), .cents(cents), .cent_vld(cent_vld),
        .timestamp(timestamp), .rd_clk(rd_clk), .empty(empty), .ser_out(ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [71:0] exp_word(vec_t v);
        logic [51:0] sm;
        logic [55:0] cm;
        for (int k = 0; k < 4; k++) sm[k*13 +: 13] = v.svld[k] ? v.stubs[k*13 +: 13] : 13'h0;
        for (int k = 0; k < 8; k++) cm[k*7 +: 7] = v.cvld[k] ? v.cents[k*7 +: 7] : 7'h0;
        case (v.mode)
            2'b11:   return {8'hFF, v.ts, v.hits};
            2'b00:   return {4'hF, v.ts, sm};
            2'b10:   return {v.ts, cm};
            default: return 72'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [71:0] act, logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mode = 2'b11; hits = '0; stubs = '0; stub_vld = '0;
        cents = '0; cent_vld = '0; timestamp = '0;
    endtask

    task automatic drive_ev(vec_t v);
        mode = v.mode; hits = v.hits; stubs = v.stubs; stub_vld = v.svld;
        cents = v.cents; cent_vld = v.cvld; timestamp = v.ts;
        @(negedge clk);
    endtask

    task automatic open_win();
        idle_inputs();
        shutter = 1'b1;
        @(negedge clk);
    endtask

    task automatic close_win();
        idle_inputs();
        shutter = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_word(output logic [71:0] w);
        for (int b = 71; b >= 0; b--) begin
            w[b] = ser_out;
            rd_clk = 1'b0;
            repeat (4) @(negedge clk);
            rd_clk = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [71:0] w;
        logic [71:0] expq [$];
        vec_t v;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset empty", {71'h0, empty}, 72'h1);
        check("R9 reset ser_out", {71'h0, ser_out}, 72'h0);

        // table walk: mixed modes, rd_clk toggled inside the window
        open_win();
        check("R1 empty after open", {71'h0, empty}, 72'h1);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) rd_clk = 1'b0;
            if (i == 5) rd_clk = 1'b1;
            drive_ev(TBL[i]);
            if (TBL[i].wr) expq.push_back(exp_word(TBL[i]));
            if (i == 0) check("R7 empty after first write", {71'h0, empty}, 72'h0);
            if (i == 4) check("R10 ser_out low during acquisition", {71'h0, ser_out}, 72'h0);
        end
        close_win();
        foreach (expq[k]) begin
            read_word(w);
            case (k)
                0: check("R2 raw word (R8 order)", w, expq[k]);
                1: check("R3 stub word (R10 rd_clk ignored)", w, expq[k]);
                2: check("R4 centroid word, R5 mode 01 skipped", w, expq[k]);
                default: check("R2 raw word top hit", w, expq[k]);
            endcase
        end
        check("R9 zero after last bit", {71'h0, ser_out}, 72'h0);
        read_word(w);
        check("R9 further edges give zero", w, 72'h0);

        // overflow: 100 raw events, first 96 survive
        open_win();
        for (int i = 0; i < 100; i++) begin
            v = '0;
            v.mode = 2'b11;
            v.hits = 48'(i + 1);
            v.ts = 16'(i);
            drive_ev(v);
        end
        close_win();
        for (int i = 0; i < 96; i++) begin
            read_word(w);
            check("R6 stored word kept", w, {8'hFF, 16'(i), 48'(i + 1)});
        end
        read_word(w);
        check("R6 dropped events not read", w, 72'h0);

        // reopen over unread data
        open_win();
        for (int i = 0; i < 3; i++) begin
            v = '0; v.mode = 2'b11; v.hits = 48'hF0F0; v.ts = 16'h1000 + 16'(i);
            drive_ev(v);
        end
        close_win();
        open_win();
        check("R1 empty after reopen", {71'h0, empty}, 72'h1);
        v = '0; v.mode = 2'b11; v.hits = 48'hABC; v.ts = 16'hABCD;
        drive_ev(v);
        close_win();
        read_word(w);
        check("R1 only new word", w, {8'hFF, 16'hABCD, 48'hABC});
        read_word(w);
        check("R1 old words gone", w, 72'h0);

        // empty window: nothing to read
        open_win();
        close_win();
        check("R7 empty stays 1 without data", {71'h0, empty}, 72'h1);
        check("R9 empty dump zero", {71'h0, ser_out}, 72'h0);

        finish_run();
    end
endmodule